// File: doc/BRIEF.md
# Golden-Priority Deflection Port Allocator

This block is the port-allocation stage of a bufferless mesh router that uses hot-potato routing. In every cycle up to four flits arrive on the North, East, South and West links. The block gives each valid flit a distinct outgoing link in that same cycle, so no flit is ever held back or dropped. A flit usually leaves on the link that brings it closer to its destination, which is its productive link. When two or more flits want the same link, one of them wins and the others are deflected onto links that are still free.

Livelock freedom comes from a single network-wide golden identity, a source address plus a packet number, that every router agrees on. A flit that carries this identity beats every other claim on its productive link. Among ordinary flits that contend for one link, the winner is picked pseudo-randomly from a free-running LFSR. The allocation is registered, so the outgoing assignment and the flit contents appear one clock after the inputs.

Top module: `dpa_golden_alloc`

## Requirements
- R1: One cycle after the inputs are presented, every valid input flit occupies exactly one output link, no output link carries two flits, and the number of valid outputs equals the number of valid inputs.
- R2: Each valid output carries the source, packet number, destination and payload of the input flit it came from, unchanged, plus that flit's input link index (0 = North, 1 = East, 2 = South, 3 = West).
- R3: Addresses are 6 bits, with the row in bits [5:3] and the column in bits [2:0]. Row numbers grow southward and column numbers grow eastward. The productive link is chosen by column first: destination column above the local column gives East, below gives West. Only when the columns are equal does the row decide: destination row above the local row gives South, below gives North. A flit addressed to the local router has no productive link.
- R4: A flit is golden only when both its source address and its 4-bit packet number equal the current golden pair. A golden flit with a productive link always leaves on that link.
- R5: A link that is the productive link of at least one valid flit is always given to one of those flits, never to a deflected flit and never left idle.
- R6: When two or more non-golden flits contend for one link, the winner is chosen pseudo-randomly, so over repeated contention every contender sometimes wins and sometimes loses.
- R7: Flits that lost arbitration, and flits with no productive link, take the links no winner holds. They are assigned in ascending input index to free links in the fixed order North, East, South, West. Free links left over are invalid.
- R8: While reset is asserted, and in the cycle after it, every output link is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| here_row_i | input | 3 | Row of this router |
| here_col_i | input | 3 | Column of this router |
| gold_src_i | input | 6 | Source address of the current golden packet |
| gold_pid_i | input | 4 | Packet number of the current golden packet |
| in_vld_i | input | 4 | Valid per input link, bit 0 North to bit 3 West |
| in_src_i | input | 24 | Source address per input link, 6 bits each |
| in_pid_i | input | 16 | Packet number per input link, 4 bits each |
| in_dst_i | input | 24 | Destination address per input link, 6 bits each |
| in_data_i | input | 64 | Payload per input link, 16 bits each |
| out_vld_o | output | 4 | Valid per output link |
| out_from_o | output | 8 | Input link index placed on each output link, 2 bits each |
| out_src_o | output | 24 | Source address per output link |
| out_pid_o | output | 16 | Packet number per output link |
| out_dst_o | output | 24 | Destination address per output link |
| out_data_o | output | 64 | Payload per output link |

## Verification
The assertions assume that the router position and golden pair inputs stay steady while a flit is in flight through the registered stage. They also assume that at most one flit of the golden packet arrives in any cycle, because with two golden flits on one productive link only one can win. The sweep keeps to these conditions. It holds the position at row 3, column 3 and the golden pair constant, and it marks at most one input link per pattern as golden. The other inputs match the golden pair on only one of the two fields. East and West destinations also differ in row, so the column-first rule is tested.

// File: rtl/dpa_pkg.sv
`timescale 1ns/1ps
package dpa_pkg;
   // Link numbering shared by inputs and outputs; the fill order for
   // deflected flits is ascending in this numbering.
   localparam int LINKS      = 4;
   localparam int LINK_IDX_W = 2;
   localparam int PORT_N     = 0;
   localparam int PORT_E     = 1;
   localparam int PORT_S     = 2;
   localparam int PORT_W     = 3;

   function automatic logic [LINK_IDX_W-1:0] onehot_to_idx(input logic [LINKS-1:0] oh);
      logic [LINK_IDX_W-1:0] idx;
      idx = '0;
      for (int i = 0; i < LINKS; i++) begin
         if (oh[i]) idx = LINK_IDX_W'(i);
      end
      return idx;
   endfunction
endpackage

// File: rtl/dpa_route_calc.sv
`timescale 1ns/1ps
module dpa_route_calc
   import dpa_pkg::*;
#(
   parameter int ROW_W = 3,
   parameter int COL_W = 3
) (
   input  logic [ROW_W-1:0] dst_row,
   input  logic [COL_W-1:0] dst_col,
   input  logic [ROW_W-1:0] here_row,
   input  logic [COL_W-1:0] here_col,
   output logic [LINKS-1:0] want
);
   // Column first, row second; a flit for this node wants nothing.
   always_comb begin
      want = '0;
      if (dst_col > here_col)      want[PORT_E] = 1'b1;
      else if (dst_col < here_col) want[PORT_W] = 1'b1;
      else if (dst_row > here_row) want[PORT_S] = 1'b1;
      else if (dst_row < here_row) want[PORT_N] = 1'b1;
   end
endmodule

// File: rtl/dpa_lfsr.sv
`timescale 1ns/1ps
module dpa_lfsr #(
   parameter int             W     = 8,
   parameter logic [W-1:0]   SEED  = 8'h5A,
   parameter logic [W-1:0]   TAPS  = 8'hB8
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state
);
   if (SEED == '0) begin : g_bad_seed
      $error("dpa_lfsr: an all-zero seed locks the register");
   end
   if (W < 3) begin : g_bad_width
      $error("dpa_lfsr: width below 3 gives no useful sequence");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEED;
      else        state <= {state[W-2:0], ^(state & TAPS)};
   end
endmodule

// File: rtl/dpa_rot_pick.sv
`timescale 1ns/1ps
module dpa_rot_pick #(
   parameter int N     = 4,
   parameter int ROT_W = 2
) (
   input  logic [N-1:0]     req,
   input  logic [ROT_W-1:0] rot,
   output logic [N-1:0]     gnt
);
   if ((1 << ROT_W) < N) begin : g_bad_rot
      $error("dpa_rot_pick: rotation field cannot reach every requester");
   end

   // First requester found when scanning upward from the rotated start.
   always_comb begin
      logic hit;
      hit = 1'b0;
      gnt = '0;
      for (int i = 0; i < N; i++) begin
         int j;
         j = (i + int'(rot)) % N;
         if (!hit && req[j]) begin
            gnt[j] = 1'b1;
            hit    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dpa_deflect_fill.sv
`timescale 1ns/1ps
module dpa_deflect_fill #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]       loser,
   input  logic [N-1:0]       port_free,
   output logic [N-1:0]       fill_vld,
   output logic [N*IDX_W-1:0] fill_idx
);
   if ((1 << IDX_W) < N) begin : g_bad_idx
      $error("dpa_deflect_fill: index field too narrow");
   end

   always_comb begin
      logic [N-1:0] avail;
      avail    = port_free;
      fill_vld = '0;
      fill_idx = '0;
      for (int k = 0; k < N; k++) begin
         logic placed;
         placed = 1'b0;
         if (loser[k]) begin
            for (int p = 0; p < N; p++) begin
               if (!placed && avail[p]) begin
                  avail[p]                     = 1'b0;
                  fill_vld[p]                  = 1'b1;
                  fill_idx[p*IDX_W +: IDX_W]   = IDX_W'(k);
                  placed                       = 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/dpa_golden_alloc.sv
`timescale 1ns/1ps
module dpa_golden_alloc
   import dpa_pkg::*;
#(
   parameter int           ROW_W     = 3,
   parameter int           COL_W     = 3,
   parameter int           PID_W     = 4,
   parameter int           DATA_W    = 16,
   parameter int           LFSR_W    = 8,
   parameter logic [7:0]   LFSR_SEED = 8'h5A,
   parameter logic [7:0]   LFSR_TAPS = 8'hB8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ROW_W-1:0]                  here_row_i,
   input  logic [COL_W-1:0]                  here_col_i,
   input  logic [ROW_W+COL_W-1:0]            gold_src_i,
   input  logic [PID_W-1:0]                  gold_pid_i,
   input  logic [LINKS-1:0]                  in_vld_i,
   input  logic [LINKS*(ROW_W+COL_W)-1:0]    in_src_i,
   input  logic [LINKS*PID_W-1:0]            in_pid_i,
   input  logic [LINKS*(ROW_W+COL_W)-1:0]    in_dst_i,
   input  logic [LINKS*DATA_W-1:0]           in_data_i,
   output logic [LINKS-1:0]                  out_vld_o,
   output logic [LINKS*LINK_IDX_W-1:0]       out_from_o,
   output logic [LINKS*(ROW_W+COL_W)-1:0]    out_src_o,
   output logic [LINKS*PID_W-1:0]            out_pid_o,
   output logic [LINKS*(ROW_W+COL_W)-1:0]    out_dst_o,
   output logic [LINKS*DATA_W-1:0]           out_data_o
);
   localparam int ADDR_W = ROW_W + COL_W;
   localparam int N      = LINKS;
   localparam int IDX_W  = LINK_IDX_W;
   localparam int ROT_W  = $clog2(N);
   localparam int RND_W  = N * ROT_W;

   // ---------------- elaboration checks ----------------
   if (LFSR_W < RND_W) begin : g_bad_lfsr
      $error("dpa_golden_alloc: LFSR narrower than the per-link rotation fields");
   end
   if (LFSR_W > 8) begin : g_bad_lfsr_max
      $error("dpa_golden_alloc: seed and tap parameters hold 8 bits");
   end
   if (ROW_W < 1 || COL_W < 1 || PID_W < 1 || DATA_W < 1) begin : g_bad_field
      $error("dpa_golden_alloc: every field needs at least one bit");
   end

   // ---------------- random source ----------------
   logic [LFSR_W-1:0] lfsr_q;

   dpa_lfsr #(
      .W    (LFSR_W),
      .SEED (LFSR_SEED[LFSR_W-1:0]),
      .TAPS (LFSR_TAPS[LFSR_W-1:0])
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .state (lfsr_q)
   );

   // ---------------- per input: golden match and productive link ----------------
   logic [N-1:0] is_gold;
   logic [N-1:0] want [N];

   for (genvar k = 0; k < N; k++) begin : g_lane
      logic [ADDR_W-1:0] dst_k;
      assign dst_k = in_dst_i[k*ADDR_W +: ADDR_W];

      assign is_gold[k] = in_vld_i[k]
                        & (in_src_i[k*ADDR_W +: ADDR_W] == gold_src_i)
                        & (in_pid_i[k*PID_W +: PID_W]   == gold_pid_i);

      dpa_route_calc #(
         .ROW_W (ROW_W),
         .COL_W (COL_W)
      ) u_route (
         .dst_row  (dst_k[ADDR_W-1 -: ROW_W]),
         .dst_col  (dst_k[COL_W-1:0]),
         .here_row (here_row_i),
         .here_col (here_col_i),
         .want     (want[k])
      );
   end

   // ---------------- per output: arbitration of productive claims ----------------
   logic [N-1:0] gnt [N];
   logic [N-1:0] taken;

   for (genvar p = 0; p < N; p++) begin : g_port
      logic [N-1:0] req_all;
      logic [N-1:0] req_gold;
      logic [N-1:0] req_use;

      for (genvar k = 0; k < N; k++) begin : g_req
         assign req_all[k] = in_vld_i[k] & want[k][p];
      end

      assign req_gold = req_all & is_gold;
      assign req_use  = (|req_gold) ? req_gold : req_all;
      assign taken[p] = |req_all;

      dpa_rot_pick #(
         .N     (N),
         .ROT_W (ROT_W)
      ) u_pick (
         .req (req_use),
         .rot (lfsr_q[p*ROT_W +: ROT_W]),
         .gnt (gnt[p])
      );
   end

   // ---------------- deflection of everything that did not win ----------------
   logic [N-1:0]       won;
   logic [N-1:0]       loser;
   logic [N-1:0]       fill_vld;
   logic [N*IDX_W-1:0] fill_idx;

   always_comb begin
      won = '0;
      for (int p = 0; p < N; p++) won |= gnt[p];
   end

   assign loser = in_vld_i & ~won;

   dpa_deflect_fill #(
      .N     (N),
      .IDX_W (IDX_W)
   ) u_fill (
      .loser     (loser),
      .port_free (~taken),
      .fill_vld  (fill_vld),
      .fill_idx  (fill_idx)
   );

   // ---------------- crossbar select ----------------
   logic [N-1:0]        nx_vld;
   logic [N*IDX_W-1:0]  nx_from;
   logic [N*ADDR_W-1:0] nx_src;
   logic [N*PID_W-1:0]  nx_pid;
   logic [N*ADDR_W-1:0] nx_dst;
   logic [N*DATA_W-1:0] nx_data;

   always_comb begin
      nx_vld  = '0;
      nx_from = '0;
      nx_src  = '0;
      nx_pid  = '0;
      nx_dst  = '0;
      nx_data = '0;
      for (int p = 0; p < N; p++) begin
         logic [IDX_W-1:0] sel;
         if (taken[p]) begin
            nx_vld[p] = 1'b1;
            sel       = onehot_to_idx(gnt[p]);
         end else begin
            nx_vld[p] = fill_vld[p];
            sel       = fill_idx[p*IDX_W +: IDX_W];
         end
         if (nx_vld[p]) begin
            nx_from[p*IDX_W  +: IDX_W]  = sel;
            nx_src [p*ADDR_W +: ADDR_W] = in_src_i [int'(sel)*ADDR_W +: ADDR_W];
            nx_pid [p*PID_W  +: PID_W]  = in_pid_i [int'(sel)*PID_W  +: PID_W];
            nx_dst [p*ADDR_W +: ADDR_W] = in_dst_i [int'(sel)*ADDR_W +: ADDR_W];
            nx_data[p*DATA_W +: DATA_W] = in_data_i[int'(sel)*DATA_W +: DATA_W];
         end
      end
   end

   // ---------------- output register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld_o  <= '0;
         out_from_o <= '0;
         out_src_o  <= '0;
         out_pid_o  <= '0;
         out_dst_o  <= '0;
         out_data_o <= '0;
      end else begin
         out_vld_o  <= nx_vld;
         out_from_o <= nx_from;
         out_src_o  <= nx_src;
         out_pid_o  <= nx_pid;
         out_dst_o  <= nx_dst;
         out_data_o <= nx_data;
      end
   end
endmodule

// File: rtl/dpa_alloc_chk.sv
`timescale 1ns/1ps
module dpa_alloc_chk
   import dpa_pkg::*;
#(
   parameter int ROW_W  = 3,
   parameter int COL_W  = 3,
   parameter int PID_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ROW_W-1:0]                  here_row_i,
   input  logic [COL_W-1:0]                  here_col_i,
   input  logic [ROW_W+COL_W-1:0]            gold_src_i,
   input  logic [PID_W-1:0]                  gold_pid_i,
   input  logic [LINKS-1:0]                  in_vld_i,
   input  logic [LINKS*(ROW_W+COL_W)-1:0]    in_src_i,
   input  logic [LINKS*PID_W-1:0]            in_pid_i,
   input  logic [LINKS*(ROW_W+COL_W)-1:0]    in_dst_i,
   input  logic [LINKS*DATA_W-1:0]           in_data_i,
   input  logic [LINKS-1:0]                  out_vld_o,
   input  logic [LINKS*LINK_IDX_W-1:0]       out_from_o,
   input  logic [LINKS*(ROW_W+COL_W)-1:0]    out_src_o,
   input  logic [LINKS*PID_W-1:0]            out_pid_o,
   input  logic [LINKS*(ROW_W+COL_W)-1:0]    out_dst_o,
   input  logic [LINKS*DATA_W-1:0]           out_data_o
);
   localparam int ADDR_W = ROW_W + COL_W;
   localparam int N      = LINKS;
   localparam int IDX_W  = LINK_IDX_W;

   logic                primed;
   logic [N-1:0]        pv_vld;
   logic [N*ADDR_W-1:0] pv_src;
   logic [N*PID_W-1:0]  pv_pid;
   logic [N*ADDR_W-1:0] pv_dst;
   logic [N*DATA_W-1:0] pv_data;
   logic [ADDR_W-1:0]   pv_gsrc;
   logic [PID_W-1:0]    pv_gpid;
   logic [ROW_W-1:0]    pv_row;
   logic [COL_W-1:0]    pv_col;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed  <= 1'b0;
         pv_vld  <= '0;
         pv_src  <= '0;
         pv_pid  <= '0;
         pv_dst  <= '0;
         pv_data <= '0;
         pv_gsrc <= '0;
         pv_gpid <= '0;
         pv_row  <= '0;
         pv_col  <= '0;
      end else begin
         primed  <= 1'b1;
         pv_vld  <= in_vld_i;
         pv_src  <= in_src_i;
         pv_pid  <= in_pid_i;
         pv_dst  <= in_dst_i;
         pv_data <= in_data_i;
         pv_gsrc <= gold_src_i;
         pv_gpid <= gold_pid_i;
         pv_row  <= here_row_i;
         pv_col  <= here_col_i;
      end
   end

   // Expected productive link, worked out from the registered destination;
   // N means none.
   function automatic int home_link(input logic [ADDR_W-1:0] dst);
      logic [ROW_W-1:0] r;
      logic [COL_W-1:0] c;
      r = dst[ADDR_W-1 -: ROW_W];
      c = dst[COL_W-1:0];
      if (c != pv_col) return (c > pv_col) ? PORT_E : PORT_W;
      if (r != pv_row) return (r > pv_row) ? PORT_S : PORT_N;
      return N;
   endfunction

   logic [2:0] hit_cnt [N];
   always_comb begin
      for (int k = 0; k < N; k++) begin
         hit_cnt[k] = '0;
         for (int p = 0; p < N; p++) begin
            if (out_vld_o[p] && int'(out_from_o[p*IDX_W +: IDX_W]) == k)
               hit_cnt[k] = hit_cnt[k] + 3'd1;
         end
      end
   end

   AST_SLOT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> ($countones(out_vld_o) == $countones(pv_vld)));  // R1

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> (out_vld_o == '0));  // R8

   for (genvar k = 0; k < N; k++) begin : g_in_chk
      logic pv_gold;
      int   pv_home;
      assign pv_gold = pv_vld[k]
                     && (pv_src[k*ADDR_W +: ADDR_W] == pv_gsrc)
                     && (pv_pid[k*PID_W +: PID_W]   == pv_gpid);
      assign pv_home = home_link(pv_dst[k*ADDR_W +: ADDR_W]);

      AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
         primed |-> (hit_cnt[k] == (pv_vld[k] ? 3'd1 : 3'd0)));  // R1

      AST_GOLD_HOME: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && pv_gold && pv_home < N) |->
            (out_vld_o[pv_home] && int'(out_from_o[pv_home*IDX_W +: IDX_W]) == k));  // R4
   end

   for (genvar p = 0; p < N; p++) begin : g_out_chk
      int src_k;
      assign src_k = int'(out_from_o[p*IDX_W +: IDX_W]);

      AST_PAYLOAD_INTACT: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && out_vld_o[p]) |->
            (out_data_o[p*DATA_W +: DATA_W] == pv_data[src_k*DATA_W +: DATA_W]
             && out_src_o[p*ADDR_W +: ADDR_W] == pv_src[src_k*ADDR_W +: ADDR_W]
             && out_pid_o[p*PID_W +: PID_W]   == pv_pid[src_k*PID_W +: PID_W]
             && out_dst_o[p*ADDR_W +: ADDR_W] == pv_dst[src_k*ADDR_W +: ADDR_W]));  // R2
   end
endmodule

bind dpa_golden_alloc dpa_alloc_chk #(
   .ROW_W  (ROW_W),
   .COL_W  (COL_W),
   .PID_W  (PID_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .here_row_i (here_row_i),
   .here_col_i (here_col_i),
   .gold_src_i (gold_src_i),
   .gold_pid_i (gold_pid_i),
   .in_vld_i   (in_vld_i),
   .in_src_i   (in_src_i),
   .in_pid_i   (in_pid_i),
   .in_dst_i   (in_dst_i),
   .in_data_i  (in_data_i),
   .out_vld_o  (out_vld_o),
   .out_from_o (out_from_o),
   .out_src_o  (out_src_o),
   .out_pid_o  (out_pid_o),
   .out_dst_o  (out_dst_o),
   .out_data_o (out_data_o)
);

// File: tb/dpa_golden_alloc_tb_top.sv
`timescale 1ns/1ps
module dpa_golden_alloc_tb_top;
   localparam int NL = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  here_row_i = 3'd3;
   logic [2:0]  here_col_i = 3'd3;
   logic [5:0]  gold_src_i = 6'h15;
   logic [3:0]  gold_pid_i = 4'h9;
   logic [3:0]  in_vld_i  = '0;
   logic [23:0] in_src_i  = '0;
   logic [15:0] in_pid_i  = '0;
   logic [23:0] in_dst_i  = '0;
   logic [63:0] in_data_i = '0;
   logic [3:0]  out_vld_o;
   logic [7:0]  out_from_o;
   logic [23:0] out_src_o;
   logic [15:0] out_pid_o;
   logic [23:0] out_dst_o;
   logic [63:0] out_data_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int b_dir  [NL];
   bit b_vld  [NL];
   int wins   [NL];
   int losses [NL];

   always #5 clk = ~clk;

   dpa_golden_alloc dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .here_row_i (here_row_i),
      .here_col_i (here_col_i),
      .gold_src_i (gold_src_i),
      .gold_pid_i (gold_pid_i),
      .in_vld_i   (in_vld_i),
      .in_src_i   (in_src_i),
      .in_pid_i   (in_pid_i),
      .in_dst_i   (in_dst_i),
      .in_data_i  (in_data_i),
      .out_vld_o  (out_vld_o),
      .out_from_o (out_from_o),
      .out_src_o  (out_src_o),
      .out_pid_o  (out_pid_o),
      .out_dst_o  (out_dst_o),
      .out_data_o (out_data_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // Destination per intended link around (3,3); East and West also differ
   // in row so column-first routing is exercised (R3).
   function automatic logic [5:0] dest_for(input int d);
      case (d)
         0:       return {3'd1, 3'd3};
         1:       return {3'd0, 3'd5};
         2:       return {3'd6, 3'd3};
         3:       return {3'd7, 3'd1};
         default: return {3'd3, 3'd3};
      endcase
   endfunction

   function automatic int from_of(input int p);
      return int'(out_from_o[p*2 +: 2]);
   endfunction

   task automatic drive(input int gold, input int mask, input int combo, input int serial);
      int c;
      c = combo;
      for (int k = 0; k < NL; k++) begin
         b_dir[k] = c % 5;
         c        = c / 5;
         b_vld[k] = mask[k];
         in_vld_i[k]             = mask[k];
         in_dst_i[k*6 +: 6]      = dest_for(b_dir[k]);
         in_data_i[k*16 +: 16]   = 16'((serial * 4 + k) & 16'hFFFF);
         if (k == gold) begin
            in_src_i[k*6 +: 6] = gold_src_i;
            in_pid_i[k*4 +: 4] = gold_pid_i;
         end else if ((k % 2) == 0) begin
            in_src_i[k*6 +: 6] = gold_src_i;
            in_pid_i[k*4 +: 4] = gold_pid_i ^ 4'h1;
         end else begin
            in_src_i[k*6 +: 6] = gold_src_i ^ 6'h01;
            in_pid_i[k*4 +: 4] = gold_pid_i;
         end
      end
   endtask

   task automatic evaluate(input int gold);
      int nin, nout, f, ncont, nl, nf;
      bit winner [NL];
      int losers [NL];
      int frees  [NL];
      nin = 0; nout = 0;
      for (int k = 0; k < NL; k++) if (b_vld[k]) nin++;
      for (int p = 0; p < NL; p++) if (out_vld_o[p]) nout++;
      chk(nout == nin, "R1 valid count", nout, nin);
      for (int k = 0; k < NL; k++) begin
         int seen;
         seen = 0;
         for (int p = 0; p < NL; p++) if (out_vld_o[p] && from_of(p) == k) seen++;
         chk(seen == (b_vld[k] ? 1 : 0), "R1 slots per flit", seen, b_vld[k] ? 1 : 0);
      end
      for (int p = 0; p < NL; p++) begin
         if (out_vld_o[p]) begin
            f = from_of(p);
            chk(b_vld[f] && out_data_o[p*16 +: 16] == in_data_i[f*16 +: 16]
                && out_src_o[p*6 +: 6] == in_src_i[f*6 +: 6]
                && out_pid_o[p*4 +: 4] == in_pid_i[f*4 +: 4]
                && out_dst_o[p*6 +: 6] == in_dst_i[f*6 +: 6],
                "R2 fields", int'(out_data_o[p*16 +: 16]), int'(in_data_i[f*16 +: 16]));
         end
      end
      for (int k = 0; k < NL; k++) winner[k] = 1'b0;
      // productive links
      for (int p = 0; p < NL; p++) begin
         bit gold_here;
         ncont = 0; gold_here = 1'b0;
         for (int k = 0; k < NL; k++) if (b_vld[k] && b_dir[k] == p) begin
            ncont++;
            if (k == gold) gold_here = 1'b1;
         end
         if (ncont > 0) begin
            f = from_of(p);
            if (gold_here)
               chk(out_vld_o[p] && f == gold, "R4 golden keeps its link", f, gold);
            else if (ncont == 1)
               chk(out_vld_o[p] && b_vld[f] && b_dir[f] == p, "R3 productive link", f, p);
            else
               chk(out_vld_o[p] && b_vld[f] && b_dir[f] == p, "R5 link to a contender", f, p);
            if (out_vld_o[p] && b_vld[f] && b_dir[f] == p) begin
               winner[f] = 1'b1;
               if (ncont >= 2 && !gold_here) begin
                  wins[f]++;
                  for (int k = 0; k < NL; k++)
                     if (k != f && b_vld[k] && b_dir[k] == p) losses[k]++;
               end
            end
         end
      end
      // deflection fill
      nl = 0; nf = 0;
      for (int k = 0; k < NL; k++) if (b_vld[k] && !winner[k]) begin losers[nl] = k; nl++; end
      for (int p = 0; p < NL; p++) begin
         bit claimed;
         claimed = 1'b0;
         for (int k = 0; k < NL; k++) if (b_vld[k] && b_dir[k] == p) claimed = 1'b1;
         if (!claimed) begin frees[nf] = p; nf++; end
      end
      for (int i = 0; i < nf; i++) begin
         int p;
         p = frees[i];
         if (i < nl)
            chk(out_vld_o[p] && from_of(p) == losers[i], "R7 deflect order", from_of(p), losers[i]);
         else
            chk(!out_vld_o[p], "R7 spare link idle", int'(out_vld_o[p]), 0);
      end
   endtask

   initial begin
      int serial;
      serial = 0;
      for (int k = 0; k < NL; k++) begin wins[k] = 0; losses[k] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_vld_o == 4'b0000, "R8 idle in reset", int'(out_vld_o), 0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(out_vld_o == 4'b0000, "R8 idle after reset", int'(out_vld_o), 0);
      for (int gold = 0; gold <= NL; gold++) begin
         for (int mask = 0; mask < 16; mask++) begin
            for (int combo = 0; combo < 625; combo++) begin
               drive(gold, mask, combo, serial);
               serial++;
               @(posedge clk);
               @(negedge clk);
               evaluate(gold);
            end
         end
      end
      // R6: every input must both win and lose some ordinary contests
      for (int k = 0; k < NL; k++) begin
         chk(wins[k] > 0,   "R6 contender sometimes wins",  wins[k],   1);
         chk(losses[k] > 0, "R6 contender sometimes loses", losses[k], 1);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule